// File: doc/BRIEF.md
# GPIO Port Output and Input Register Block

This block holds the data registers of an eight-pin general-purpose I/O port behind a simple synchronous register bus. The bus carries 16-bit data and byte addresses. The output value lives in one register that software can load directly. Three write-only alias addresses let software force chosen output bits high, force them low or invert them in a single write, with no read-modify-write sequence and no risk of disturbing bits that another agent owns.

On the input side, each pin passes through a first synchronising flop. It is then captured by the input data register, which acts as the second flop. A per-pin input-buffer enable gates that capture, so a pin whose buffer is disabled reads as zero. Pad drivers, output enables, pulls and interrupts live outside this block. The block drives the raw output data bus and takes the raw pin levels.

Top module: `gpio_port_regs`

## Requirements
- R1: The register offsets are 0x10 for input data, 0x14 for output data, 0x18 for bit set, 0x1C for bit clear and 0x20 for bit invert. Port bit n sits in data bit n, for n from 0 to 7.
- R2: While `rst` is high at a clock edge, the output register, the input register and `rdata` all clear to zero, so `pin_out` is 0x00.
- R3: A read at 0x10 returns, in each bit, the pin level captured two clock edges after it was applied, ANDed with that pin's `in_en` bit. A pin whose input is disabled reads 0.
- R4: A write at 0x14 loads `wdata[7:0]` into the output register, and a read at 0x14 returns it.
- R5: A write at 0x18 sets to 1 every output bit whose `wdata` bit is 1, and leaves the other bits unchanged.
- R6: A write at 0x1C clears to 0 every output bit whose `wdata` bit is 1, and leaves the other bits unchanged.
- R7: A write at 0x20 inverts every output bit whose `wdata` bit is 1, and leaves the other bits unchanged.
- R8: Reads at 0x18, 0x1C and 0x20 return 0x0000.
- R9: Bits [15:8] of every read are 0, and `wdata[15:8]` has no effect on the output.
- R10: A read at any other address returns 0x0000, and a write there leaves `pin_out` unchanged.
- R11: `pin_out` changes only on the clock edge that accepts a write. `rdata` is loaded on the edge after `rd_en` is sampled high and holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Byte address of the access |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| pin_in | input | 8 | Raw pin levels |
| in_en | input | 8 | Per-pin input-buffer enable |
| pin_out | output | 8 | Output data to the pad drivers |

## Verification
A corrupted output register appears on `pin_out` one edge after the write that caused it. Because set, clear and invert all build on the current value, an error that escapes a direct check keeps propagating into every later alias write. The bench therefore chains alias writes from a known loaded value and compares `pin_out` after each one. Faults on the input path, such as a wrong enable mask or a wrong synchroniser depth, show up only through a read. Each read result is therefore checked in the exact cycle the two-edge latency predicts, with an extra check one cycle early to confirm the old value is still reported there.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_IN  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_OUT = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_SET = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_CLR = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_TGL = 8'h20;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_IN,
    SEL_OUT,
    SEL_SET,
    SEL_CLR,
    SEL_TGL
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    case (a)
      OFS_IN:  return SEL_IN;
      OFS_OUT: return SEL_OUT;
      OFS_SET: return SEL_SET;
      OFS_CLR: return SEL_CLR;
      OFS_TGL: return SEL_TGL;
      default: return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PORT_W-1:0] pin_in,
  input  logic [PORT_W-1:0] in_en,
  output logic [PORT_W-1:0] in_q
);
  logic [PORT_W-1:0] meta_q;

  // first stage catches the asynchronous level, second stage is the
  // architectural input register and applies the buffer enable
  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      in_q   <= '0;
    end else begin
      meta_q <= pin_in;
      in_q   <= meta_q & in_en;
    end
  end
endmodule

// File: rtl/gpio_out_reg.sv
module gpio_out_reg #(
  parameter int unsigned PORT_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  gpio_port_pkg::reg_sel_e sel,
  input  logic [PORT_W-1:0]       wbits,
  output logic [PORT_W-1:0]       out_q
);
  import gpio_port_pkg::*;

  logic [PORT_W-1:0] out_d;

  always_comb begin
    out_d = out_q;
    if (wr_en) begin
      unique case (sel)
        SEL_OUT: out_d = wbits;
        SEL_SET: out_d = out_q | wbits;
        SEL_CLR: out_d = out_q & ~wbits;
        SEL_TGL: out_d = out_q ^ wbits;
        default: out_d = out_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) out_q <= '0;
    else     out_q <= out_d;
  end
endmodule

// File: rtl/gpio_rd_path.sv
module gpio_rd_path #(
  parameter int unsigned PORT_W = 8,
  parameter int unsigned DATA_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rd_en,
  input  gpio_port_pkg::reg_sel_e sel,
  input  logic [PORT_W-1:0]       in_q,
  input  logic [PORT_W-1:0]       out_q,
  output logic [DATA_W-1:0]       rdata
);
  import gpio_port_pkg::*;

  localparam int unsigned PAD_W = DATA_W - PORT_W;

  logic [PORT_W-1:0] port_val;

  always_comb begin
    unique case (sel)
      SEL_IN:  port_val = in_q;
      SEL_OUT: port_val = out_q;
      default: port_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= {{PAD_W{1'b0}}, port_val};
  end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int unsigned PORT_W = 8,
  parameter int unsigned DATA_W = 16
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr_en,
  input  logic                             rd_en,
  input  logic [gpio_port_pkg::ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]                wdata,
  output logic [DATA_W-1:0]                rdata,
  input  logic [PORT_W-1:0]                pin_in,
  input  logic [PORT_W-1:0]                in_en,
  output logic [PORT_W-1:0]                pin_out
);
  import gpio_port_pkg::*;

  reg_sel_e          sel;
  logic [PORT_W-1:0] in_q;
  logic [PORT_W-1:0] out_q;

  assign sel     = decode_addr(addr);
  assign pin_out = out_q;

  gpio_in_sync #(.PORT_W(PORT_W)) u_in (
    .clk    (clk),
    .rst    (rst),
    .pin_in (pin_in),
    .in_en  (in_en),
    .in_q   (in_q)
  );

  gpio_out_reg #(.PORT_W(PORT_W)) u_out (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_en),
    .sel   (sel),
    .wbits (wdata[PORT_W-1:0]),
    .out_q (out_q)
  );

  gpio_rd_path #(.PORT_W(PORT_W), .DATA_W(DATA_W)) u_rd (
    .clk   (clk),
    .rst   (rst),
    .rd_en (rd_en),
    .sel   (sel),
    .in_q  (in_q),
    .out_q (out_q),
    .rdata (rdata)
  );
endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk #(
  parameter int unsigned PORT_W = 8,
  parameter int unsigned DATA_W = 16
) (
  input logic                             clk,
  input logic                             rst,
  input logic                             wr_en,
  input logic                             rd_en,
  input logic [gpio_port_pkg::ADDR_W-1:0] addr,
  input logic [DATA_W-1:0]                wdata,
  input logic [DATA_W-1:0]                rdata,
  input logic [PORT_W-1:0]                pin_in,
  input logic [PORT_W-1:0]                in_en,
  input logic [PORT_W-1:0]                pin_out
);
  import gpio_port_pkg::*;

  logic [PORT_W-1:0] wb;
  assign wb = wdata[PORT_W-1:0];

  a_r2_reset_clears: assert property (@(posedge clk)
    rst |=> (pin_out == '0 && rdata == '0));

  a_r4_load: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_OUT) |=> pin_out == $past(wb));

  a_r5_set: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_SET) |=> pin_out == ($past(pin_out) | $past(wb)));

  a_r6_clear: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_CLR) |=> pin_out == ($past(pin_out) & ~$past(wb)));

  a_r7_toggle: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFS_TGL) |=> pin_out == ($past(pin_out) ^ $past(wb)));

  a_r8_alias_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (addr == OFS_SET || addr == OFS_CLR || addr == OFS_TGL)) |=> rdata == '0);

  a_r9_upper_zero: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rdata[DATA_W-1:PORT_W] == '0);

  a_r10_unmapped_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && decode_addr(addr) == SEL_NONE) |=> $stable(pin_out));

  a_r11_out_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(pin_out));

  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

  a_r3_disabled_pins_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == OFS_IN) |=> (rdata[PORT_W-1:0] & ~$past(in_en, 2)) == '0);
endmodule

bind gpio_port_regs gpio_port_regs_chk #(.PORT_W(PORT_W), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .addr    (addr),
  .wdata   (wdata),
  .rdata   (rdata),
  .pin_in  (pin_in),
  .in_en   (in_en),
  .pin_out (pin_out)
);

// File: tb/gpio_port_regs_bench.sv
module gpio_port_regs_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, rd_en;
  logic [7:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic [7:0]  pin_in, in_en, pin_out;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  gpio_port_regs u_gpio_port_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .in_en(in_en), .pin_out(pin_out)
  );

  typedef struct packed {
    logic [7:0]  a;
    logic [15:0] d;
    logic [7:0]  e;
    logic [3:0]  r;
  } vec_t;

  // write address, write data, expected pin_out, requirement number
  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{8'h14, 16'h00A5, 8'hA5, 4'd4},   // R4 load
    '{8'h18, 16'h0042, 8'hE7, 4'd5},   // R5 set
    '{8'h1C, 16'h0081, 8'h66, 4'd6},   // R6 clear
    '{8'h20, 16'h00FF, 8'h99, 4'd7},   // R7 invert all
    '{8'h20, 16'h0000, 8'h99, 4'd7},   // R7 zero mask
    '{8'h18, 16'h0000, 8'h99, 4'd5},   // R5 zero mask
    '{8'h1C, 16'h0000, 8'h99, 4'd6},   // R6 zero mask
    '{8'h14, 16'hFF3C, 8'h3C, 4'd9},   // R9 upper bits ignored
    '{8'h24, 16'h00FF, 8'h3C, 4'd10},  // R10 unmapped
    '{8'h12, 16'h00FF, 8'h3C, 4'd10},  // R10 misaligned
    '{8'h18, 16'h00C0, 8'hFC, 4'd5},   // R5 set upper pins
    '{8'h1C, 16'hFFFF, 8'h00, 4'd6}    // R6 clear all
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    d = rdata;
    rd_en = 1'b0;
  endtask

  initial begin
    logic [15:0] rv;
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    pin_in = '0; in_en = '0;
    repeat (3) @(negedge clk);
    check("R2 pin_out after reset", {8'h00, pin_out}, 16'h0000);
    check("R2 rdata after reset", rdata, 16'h0000);
    rst = 1'b0;
    do_read(8'h14, rv);
    check("R2 output register reads zero", rv, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      do_write(VECS[i].a, VECS[i].d);
      check($sformatf("R%0d vector %0d pin_out", VECS[i].r, i), {8'h00, pin_out}, {8'h00, VECS[i].e});
    end

    // readback of output register and alias addresses
    do_write(8'h14, 16'h005A);
    do_read(8'h14, rv);
    check("R4 output readback", rv, 16'h005A);
    do_read(8'h18, rv);
    check("R8 set alias reads zero", rv, 16'h0000);
    do_read(8'h1C, rv);
    check("R8 clear alias reads zero", rv, 16'h0000);
    do_read(8'h20, rv);
    check("R8 invert alias reads zero", rv, 16'h0000);
    do_read(8'h24, rv);
    check("R10 unmapped read zero", rv, 16'h0000);
    check("R1 output offset kept value", {8'h00, pin_out}, 16'h005A);

    // input latency: pin changes at the same negedge as the first read
    in_en = 8'hFF;
    repeat (3) @(negedge clk);
    rd_en = 1'b1; addr = 8'h10; pin_in = 8'hC3;
    @(negedge clk);
    check("R3 input one edge after change still old", rdata, 16'h0000);
    @(negedge clk);
    check("R3 input second read still old", rdata, 16'h0000);
    @(negedge clk);
    check("R3 input visible after two edges", rdata, 16'h00C3);
    rd_en = 1'b0;

    // input-buffer enable gating
    in_en = 8'h0F; pin_in = 8'hFF;
    repeat (3) @(negedge clk);
    do_read(8'h10, rv);
    check("R3 disabled pins read zero", rv, 16'h000F);
    in_en = 8'h00;
    repeat (3) @(negedge clk);
    do_read(8'h10, rv);
    check("R3 all inputs disabled", rv, 16'h0000);

    // rdata holds while idle, pin_out holds without writes
    do_read(8'h14, rv);
    do_write(8'h20, 16'h00FF);
    check("R11 rdata holds without read", rdata, 16'h005A);
    check("R7 invert via alias", {8'h00, pin_out}, 16'h00A5);
    repeat (4) @(negedge clk);
    check("R11 pin_out stable with no write", {8'h00, pin_out}, 16'h00A5);

    // mid-run reset
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R2 reset clears output", {8'h00, pin_out}, 16'h0000);
    check("R2 reset clears rdata", rdata, 16'h0000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule